// File: doc/BRIEF.md
# Configurable program memory decoder

This block watches the 16-bit program-fetch address of an 8-bit microcontroller core and decides, for every fetch, whether the word comes from on-chip ROM or from the external program memory port. On-chip ROM always starts at address 0000h and is one contiguous region. Its top end is set by a 3-bit size code held in a protected register. The code selects 0, 1, 2, 4 or 8 KB. Any fetch above the selected top goes out to the external port.

The size register cannot be written at any time. Software first writes the key AAh and then the key 55h to a timed-access register. This opens a short window, and a write to the size register inside that window loads the new code. Reserved codes are refused. Software can shrink the internal region and later grow it back while running, so that a range of addresses is handed to external memory and then taken back. After reset the full 8 KB is mapped internally, so software that never touches the register needs no setup.

Top module: `fetch_region_select`

## Requirements
- R1: After reset the size code is 100. Fetch addresses 0000h to 1FFFh give selExternal = 0, and addresses 2000h to FFFFh give selExternal = 1.
- R2: Size codes 001, 010 and 011 map 0000h–03FFh, 0000h–07FFh and 0000h–0FFFh internally. Every address above the selected top gives selExternal = 1.
- R3: Size code 000 makes every fetch address in the 64 KB space external (selExternal = 1).
- R4: A write of AAh to the timed-access register (register address C7h), followed within 3 cycles by a write of 55h to the same register, raises windowOpen. windowOpen is then high for exactly the 3 cycles after the 55h write.
- R5: A write to the size register (register address C2h, code in data bits 2:0) while windowOpen is high loads the code. The selExternal output follows the new code from the cycle after the write.
- R6: A size register write while windowOpen is low, including after the window has expired, is ignored, and the mapping is unchanged.
- R7: A write of a reserved code (101, 110, 111) is rejected even while windowOpen is high, and the previous code is kept.
- R8: The 55h key is refused, and windowOpen stays low, if it arrives more than 3 cycles after AAh. It is also refused if any other value was written to the timed-access register in between.
- R9: A size register write inside the window closes the window, so that a second size write without a fresh unlock is ignored.
- R10: The size can be reduced and later restored at runtime. After the restore, the same addresses map internally again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe, one write per cycle |
| regWrAddr | input | 8 | Register address of the write |
| regWrData | input | 8 | Register write data |
| fetchAddr | input | 16 | Program-fetch address |
| selExternal | output | 1 | 1 = fetch goes to external memory port, 0 = on-chip ROM |
| windowOpen | output | 1 | Timed-access window currently open |

## Verification
The assertions assume that a write is at most one per cycle and is carried on a single regWrEn strobe. They also assume that fetchAddr is stable whenever it is sampled. The stored size code may change only in the cycle after an accepted write. The stimulus holds to this by driving every write for exactly one cycle from the bench tasks and releasing the strobe after the clock edge. Random writes cover all eight code values and both key bytes, plus unrelated data and register addresses. They are interleaved with idle cycles so that the windows expire at every possible point.

// File: rtl/fetch_region_pkg.sv
package fetch_region_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    TA_IDLE  = 2'd0,
    TA_ARMED = 2'd1,
    TA_OPEN  = 2'd2
  } taState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              loadSize;
    logic [CODE_W-1:0] code;
  } sizeStrobe_t;

endpackage

// File: rtl/fetch_region_ctrl.sv
module fetch_region_ctrl
  import fetch_region_pkg::*;
#(
  parameter int          REG_AW     = 8,
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  TA_ADDR    = 8'hC7,
  parameter logic [7:0]  SIZE_ADDR  = 8'hC2,
  parameter logic [7:0]  KEY_FIRST  = 8'hAA,
  parameter logic [7:0]  KEY_SECOND = 8'h55,
  parameter int          WINDOW     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  output sizeStrobe_t       strobe,
  output logic              windowOpen
);

  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WINDOW);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  taState_e         stateQ;
  logic [CNT_W-1:0] cntQ;
  logic             taWr;
  logic             sizeWr;
  logic             isOpen;

  assign taWr   = regWrEn && (regWrAddr == REG_AW'(TA_ADDR));
  assign sizeWr = regWrEn && (regWrAddr == REG_AW'(SIZE_ADDR));
  assign isOpen = (stateQ == TA_OPEN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= TA_IDLE;
      cntQ   <= '0;
    end else if (taWr) begin
      if (regWrData == DATA_W'(KEY_FIRST)) begin
        stateQ <= TA_ARMED;
        cntQ   <= CNT_LOAD;
      end else if (regWrData == DATA_W'(KEY_SECOND) && stateQ == TA_ARMED) begin
        stateQ <= TA_OPEN;
        cntQ   <= CNT_LOAD;
      end else begin
        stateQ <= TA_IDLE;
        cntQ   <= '0;
      end
    end else if (sizeWr && isOpen) begin
      stateQ <= TA_IDLE;
      cntQ   <= '0;
    end else if (stateQ != TA_IDLE) begin
      if (cntQ == CNT_LAST) begin
        stateQ <= TA_IDLE;
        cntQ   <= '0;
      end else begin
        cntQ <= cntQ - CNT_LAST;
      end
    end
  end

  always_comb begin
    strobe.loadSize = sizeWr && isOpen;
    strobe.code     = regWrData[CODE_W-1:0];
  end

  assign windowOpen = isOpen;

endmodule

// File: rtl/fetch_region_dp.sv
module fetch_region_dp
  import fetch_region_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BASE_LOG2  = 10,
  parameter int MAX_CODE   = 4,
  parameter int RESET_CODE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  sizeStrobe_t       strobe,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic [CODE_W-1:0] sizeCode,
  output logic              selExternal
);

  localparam int NUM_CODES = 2 ** CODE_W;
  localparam logic [CODE_W-1:0] MAX_C   = CODE_W'(MAX_CODE);
  localparam logic [CODE_W-1:0] RESET_C = CODE_W'(RESET_CODE);

  logic [CODE_W-1:0]    sizeQ;
  logic [NUM_CODES-1:0] regionHit;
  logic                 codeValid;
  logic                 internalHit;

  assign codeValid = (strobe.code <= MAX_C);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeQ <= RESET_C;
    end else if (strobe.loadSize && codeValid) begin
      sizeQ <= strobe.code;
    end
  end

  // one compare per size code: region k spans 2^(BASE_LOG2+k-1) bytes
  genvar k;
  generate
    for (k = 0; k < NUM_CODES; k++) begin : g_region
      if (k == 0 || k > MAX_CODE) begin : g_none
        assign regionHit[k] = 1'b0;
      end else begin : g_cmp
        localparam int TOP_BIT = BASE_LOG2 + k - 1;
        assign regionHit[k] = (fetchAddr[ADDR_W-1:TOP_BIT] == '0);
      end
    end
  endgenerate

  assign internalHit = regionHit[sizeQ];
  assign selExternal = !internalHit;
  assign sizeCode    = sizeQ;

endmodule

// File: rtl/fetch_region_select.sv
module fetch_region_select
  import fetch_region_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          REG_AW     = 8,
  parameter int          DATA_W     = 8,
  parameter int          BASE_LOG2  = 10,
  parameter int          MAX_CODE   = 4,
  parameter int          RESET_CODE = 4,
  parameter int          WINDOW     = 3,
  parameter logic [7:0]  TA_ADDR    = 8'hC7,
  parameter logic [7:0]  SIZE_ADDR  = 8'hC2,
  parameter logic [7:0]  KEY_FIRST  = 8'hAA,
  parameter logic [7:0]  KEY_SECOND = 8'h55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              selExternal,
  output logic              windowOpen
);

  sizeStrobe_t       strobe;
  logic [CODE_W-1:0] sizeQ;

  fetch_region_ctrl #(
    .REG_AW    (REG_AW),
    .DATA_W    (DATA_W),
    .TA_ADDR   (TA_ADDR),
    .SIZE_ADDR (SIZE_ADDR),
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND),
    .WINDOW    (WINDOW)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .regWrData (regWrData),
    .strobe    (strobe),
    .windowOpen(windowOpen)
  );

  fetch_region_dp #(
    .ADDR_W    (ADDR_W),
    .BASE_LOG2 (BASE_LOG2),
    .MAX_CODE  (MAX_CODE),
    .RESET_CODE(RESET_CODE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fetchAddr  (fetchAddr),
    .sizeCode   (sizeQ),
    .selExternal(selExternal)
  );

endmodule

// File: rtl/fetch_region_chk.sv
module fetch_region_chk
  import fetch_region_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          REG_AW     = 8,
  parameter int          DATA_W     = 8,
  parameter int          BASE_LOG2  = 10,
  parameter int          MAX_CODE   = 4,
  parameter logic [7:0]  TA_ADDR    = 8'hC7,
  parameter logic [7:0]  SIZE_ADDR  = 8'hC2,
  parameter logic [7:0]  KEY_SECOND = 8'h55
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regWrAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              selExternal,
  input logic              windowOpen,
  input logic [CODE_W-1:0] sizeQ
);

  localparam int TOP_BIT = BASE_LOG2 + MAX_CODE - 1;

  // R7
  code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    sizeQ <= CODE_W'(MAX_CODE));

  // R6
  code_guarded_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sizeQ) |-> $past(windowOpen && regWrEn && regWrAddr == REG_AW'(SIZE_ADDR)));

  // R1
  above_max_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchAddr[ADDR_W-1:TOP_BIT] != '0) |-> selExternal);

  // R3
  zero_size_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sizeQ == '0) |-> selExternal);

  // R4
  open_after_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(windowOpen) |-> $past(regWrEn && regWrAddr == REG_AW'(TA_ADDR)
                                && regWrData == DATA_W'(KEY_SECOND)));

  // R9
  close_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (windowOpen && regWrEn && regWrAddr == REG_AW'(SIZE_ADDR)) |=> !windowOpen);

endmodule

bind fetch_region_select fetch_region_chk #(
  .ADDR_W    (ADDR_W),
  .REG_AW    (REG_AW),
  .DATA_W    (DATA_W),
  .BASE_LOG2 (BASE_LOG2),
  .MAX_CODE  (MAX_CODE),
  .TA_ADDR   (TA_ADDR),
  .SIZE_ADDR (SIZE_ADDR),
  .KEY_SECOND(KEY_SECOND)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regWrAddr  (regWrAddr),
  .regWrData  (regWrData),
  .fetchAddr  (fetchAddr),
  .selExternal(selExternal),
  .windowOpen (windowOpen),
  .sizeQ      (sizeQ)
);

// File: tb/fetch_region_select_bench.sv
`timescale 1ns/1ps
module fetch_region_select_bench;

  localparam logic [7:0] TA   = 8'hC7;
  localparam logic [7:0] SZ   = 8'hC2;
  localparam logic [7:0] K1   = 8'hAA;
  localparam logic [7:0] K2   = 8'h55;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrAddr = 8'h00;
  logic [7:0]  regWrData = 8'h00;
  logic [15:0] fetchAddr = 16'h0000;
  logic        selExternal;
  logic        windowOpen;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench reference state: 0 idle, 1 armed, 2 open
  int mState = 0;
  int mCnt = 0;
  int mCode = 4;

  always #2 clk = ~clk;

  fetch_region_select u_fetch_region_select (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .fetchAddr  (fetchAddr),
    .selExternal(selExternal),
    .windowOpen (windowOpen)
  );

  function automatic bit expExt(input logic [15:0] a, input int code);
    if (code == 0) return 1'b1;
    return (32'(a) >= (32'd1 << (9 + code)));
  endfunction

  function automatic logic [15:0] topAddr(input int code);
    if (code == 0) return 16'h0000;
    return 16'((32'd1 << (9 + code)) - 1);
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic modelEdge(input bit we, input logic [7:0] a, input logic [7:0] d);
    if (we && a == TA) begin
      if (d == K1) begin mState = 1; mCnt = 3; end
      else if (d == K2 && mState == 1) begin mState = 2; mCnt = 3; end
      else begin mState = 0; mCnt = 0; end
    end else if (we && a == SZ && mState == 2) begin
      if (int'(d[2:0]) <= 4) mCode = int'(d[2:0]);
      mState = 0; mCnt = 0;
    end else if (mState != 0) begin
      if (mCnt == 1) begin mState = 0; mCnt = 0; end
      else mCnt--;
    end
  endtask

  // one clock cycle with an optional write; window state checked after the edge
  task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    regWrEn = we; regWrAddr = a; regWrData = d;
    @(posedge clk);
    modelEdge(we, a, d);
    #0.5;
    regWrEn = 1'b0;
    check(windowOpen, (mState == 2), tag);
  endtask

  task automatic probe(input logic [15:0] a, input bit exp, input string tag);
    fetchAddr = a;
    #0.1;
    check(selExternal, exp, tag);
  endtask

  task automatic unlock();
    step(1'b1, TA, K1, "R4 key1");
    step(1'b1, TA, K2, "R4 key2");
  endtask

  task automatic setSize(input logic [2:0] c, input string tag);
    unlock();
    step(1'b1, SZ, {5'b0, c}, tag);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #0.5;
    // reset state
    check(windowOpen, 1'b0, "R1 reset window");
    probe(16'h0000, 1'b0, "R1 0000");
    probe(16'h1FFF, 1'b0, "R1 1FFF");
    probe(16'h2000, 1'b1, "R1 2000");
    probe(16'hFFFF, 1'b1, "R1 FFFF");

    // size write without unlock
    step(1'b1, SZ, 8'h01, "R6 locked write");
    probe(16'h0400, 1'b0, "R6 locked 0400");

    // window length exactly three cycles
    unlock();
    step(1'b0, 8'h00, 8'h00, "R4 open 2");
    step(1'b0, 8'h00, 8'h00, "R4 open 3");
    step(1'b0, 8'h00, 8'h00, "R4 closed");
    check(windowOpen, 1'b0, "R4 expired");
    step(1'b1, SZ, 8'h01, "R6 expired write");
    probe(16'h0400, 1'b0, "R6 expired 0400");

    // codes 1..3 boundaries, effect next cycle
    setSize(3'd1, "R5 load 1");
    probe(16'h03FF, 1'b0, "R2 03FF c1");
    probe(16'h0400, 1'b1, "R2 0400 c1");
    check(windowOpen, 1'b0, "R9 closed by write");
    step(1'b1, SZ, 8'h04, "R9 second write");
    probe(16'h0400, 1'b1, "R9 second ignored");
    setSize(3'd2, "R5 load 2");
    probe(16'h07FF, 1'b0, "R2 07FF c2");
    probe(16'h0800, 1'b1, "R2 0800 c2");
    setSize(3'd3, "R5 load 3");
    probe(16'h0FFF, 1'b0, "R2 0FFF c3");
    probe(16'h1000, 1'b1, "R2 1000 c3");

    // zero size then restore
    setSize(3'd0, "R5 load 0");
    probe(16'h0000, 1'b1, "R3 0000");
    probe(16'h03FF, 1'b1, "R3 03FF");
    setSize(3'd4, "R10 restore");
    probe(16'h1FFF, 1'b0, "R10 1FFF");
    probe(16'h0000, 1'b0, "R10 0000");

    // reserved codes rejected
    setSize(3'd1, "R5 load 1b");
    setSize(3'd7, "R7 write 7");
    probe(16'h0000, 1'b0, "R7 0000 kept");
    probe(16'h0400, 1'b1, "R7 0400 kept");
    setSize(3'd5, "R7 write 5");
    probe(16'h03FF, 1'b0, "R7 03FF kept");

    // second key too late
    step(1'b1, TA, K1, "R8 key1");
    step(1'b0, 8'h00, 8'h00, "R8 wait");
    step(1'b0, 8'h00, 8'h00, "R8 wait");
    step(1'b0, 8'h00, 8'h00, "R8 wait");
    step(1'b1, TA, K2, "R8 late key2");
    check(windowOpen, 1'b0, "R8 late refused");
    // wrong data between keys
    step(1'b1, TA, K1, "R8 key1");
    step(1'b1, TA, 8'h12, "R8 junk");
    step(1'b1, TA, K2, "R8 key2 after junk");
    check(windowOpen, 1'b0, "R8 junk refused");
    // last allowed cycle for key2, and write in last open cycle
    step(1'b1, TA, K1, "R8 key1");
    step(1'b0, 8'h00, 8'h00, "R8 wait");
    step(1'b0, 8'h00, 8'h00, "R8 wait");
    step(1'b1, TA, K2, "R8 key2 last cycle");
    check(windowOpen, 1'b1, "R8 in-time open");
    step(1'b0, 8'h00, 8'h00, "R4 open");
    step(1'b0, 8'h00, 8'h00, "R4 open");
    step(1'b1, SZ, 8'hF8, "R5 last cycle load 0, upper bits ignored");
    probe(16'h0000, 1'b1, "R5 last cycle 0000");

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [7:0] a;
      logic [7:0] d;
      bit we;
      op = int'($urandom_range(0, 9));
      we = 1'b1;
      case (op)
        0, 1:    begin a = TA; d = K1; end
        2, 3:    begin a = TA; d = K2; end
        4, 5:    begin a = SZ; d = 8'($urandom_range(0, 255)); end
        6:       begin a = TA; d = 8'($urandom_range(0, 255)); end
        7:       begin a = 8'($urandom_range(0, 255)); d = 8'($urandom_range(0, 255)); end
        default: begin we = 1'b0; a = 8'h00; d = 8'h00; end
      endcase
      step(we, a, d, "R4 R8 R9 random window");
      begin
        logic [15:0] ra;
        logic [15:0] tp;
        ra = 16'($urandom_range(0, 65535));
        if (op == 8) ra = ra & 16'h1FFF;
        tp = topAddr(mCode);
        probe(ra, expExt(ra, mCode), "R2 R5 R6 R7 random addr");
        probe(tp, expExt(tp, mCode), "R2 R10 random top");
        probe(tp + 16'h1, expExt(tp + 16'h1, mCode), "R2 R3 random top+1");
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule